// File: doc/BRIEF.md
# Packed Binary64 Category Tester

The block takes up to eight IEEE-754 double-precision lanes and reports, per lane, whether the value falls into any of a chosen set of special categories. An 8-bit category selector picks the categories. The eight possible categories are quiet NaN, positive zero, negative zero, positive infinity, negative infinity, denormal, negative finite and signaling NaN. A lane's result bit is set when its value matches at least one selected category.

The number of active lanes follows a vector-length code. Any lane can be forced to zero through an optional write mask. With broadcast, all lanes test one shared scalar operand. A denormals-are-zero control makes values with an all-zero exponent count as signed zeros. The result is registered and marked with a one-cycle valid strobe, so a vector pipeline can drop the block in as a single stage.

Top module: `fpclass_pd`

## Requirements
- R1: Selector bit k enables one category: bit 0 quiet NaN, bit 1 +0, bit 2 -0, bit 3 +infinity, bit 4 -infinity, bit 5 denormal, bit 6 negative finite, bit 7 signaling NaN. A lane's bit is the OR over k of (sel_i[k] AND the lane matches category k).
- R2: A lane value uses bit 63 as the sign, bits 62:52 as the exponent and bits 51:0 as the fraction. Exponent all ones with a zero fraction is an infinity. Exponent all zeros with a zero fraction is a zero. The sign picks + or -.
- R3: Exponent all ones with a nonzero fraction is a NaN. It is quiet when fraction bit 51 is 1 and signaling when bit 51 is 0.
- R4: With daz_i high, a value whose exponent is all zeros counts as a signed zero whatever its fraction. It then matches +0 or -0 and never matches denormal. With daz_i low, a nonzero fraction under a zero exponent is a denormal of either sign.
- R5: Negative finite matches when the sign is 1, the exponent is not all ones and the value is not a zero. This includes negative denormals and excludes -0, -infinity and NaNs.
- R6: vl_i selects the active lane count: 0 gives 2 lanes, 1 gives 4, and 2 or 3 give 8. Lane j takes src_i[64*j+63:64*j]. Result bits at and above the active count are 0.
- R7: With wmask_en_i high, each lane whose wmask_i bit is 0 yields 0. With wmask_en_i low, wmask_i has no effect.
- R8: With bcast_i high, every active lane classifies scalar_i instead of its own slice of src_i.
- R9: A request on valid_i produces valid_o high on the next clock, with mask_o holding that request's result. Without a request, valid_o is low and mask_o keeps its last value.
- R10: While rst_ni is low, valid_o and mask_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| src_i | input | 512 | Packed source lanes, lane 0 in the low bits |
| scalar_i | input | 64 | Shared operand used when broadcasting |
| sel_i | input | 8 | Category selector |
| wmask_i | input | 8 | Per-lane write mask |
| wmask_en_i | input | 1 | Applies wmask_i when high |
| vl_i | input | 2 | Vector-length code |
| bcast_i | input | 1 | Broadcast scalar_i to all lanes |
| daz_i | input | 1 | Treats zero-exponent values as zero |
| valid_o | output | 1 | Result strobe |
| mask_o | output | 8 | Per-lane result bits |

## Verification
The bench builds the block with its default eight lanes of binary64. This keeps the lane count small enough to sweep every selector value against a catalogue of sixteen boundary encodings in both denormals-are-zero settings. The catalogue includes both zeros, both infinities, both NaN kinds near the quiet-bit edge, denormals of each sign and finite extremes. The same size lets every write mask be crossed with every vector-length code and the broadcast flag. A random phase then compares arbitrary operands and controls against an arithmetic model computed in the bench.

// File: rtl/fpclass_pkg.sv
package fpclass_pkg;
  localparam int unsigned LANE_W    = 64;
  localparam int unsigned EXP_W     = 11;
  localparam int unsigned FRAC_W    = 52;
  localparam int unsigned NUM_CAT   = 8;
  localparam int unsigned MAX_LANES = 8;
  localparam int unsigned VL_W      = 2;

  // category index == selector bit position
  localparam int unsigned CAT_QNAN = 0;
  localparam int unsigned CAT_PZER = 1;
  localparam int unsigned CAT_NZER = 2;
  localparam int unsigned CAT_PINF = 3;
  localparam int unsigned CAT_NINF = 4;
  localparam int unsigned CAT_DENO = 5;
  localparam int unsigned CAT_NFIN = 6;
  localparam int unsigned CAT_SNAN = 7;

  typedef logic [NUM_CAT-1:0] cat_vec_t;

  typedef enum logic [VL_W-1:0] {
    VL_2  = 2'd0,
    VL_4  = 2'd1,
    VL_8  = 2'd2,
    VL_8R = 2'd3
  } vl_e;

  function automatic int unsigned active_lanes(input logic [VL_W-1:0] vl);
    case (vl)
      VL_2:    return 2;
      VL_4:    return 4;
      default: return MAX_LANES;
    endcase
  endfunction
endpackage

// File: rtl/fpclass_lane.sv
module fpclass_lane
  import fpclass_pkg::*;
(
  input  logic [LANE_W-1:0] val_i,
  input  cat_vec_t          sel_i,
  input  logic              daz_i,
  output logic              hit_o
);
  logic              sign;
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic              exp_ones, exp_zero, frac_zero, is_zero, quiet;
  cat_vec_t          cat;

  always_comb begin
    sign      = val_i[LANE_W-1];
    expo      = val_i[LANE_W-2 -: EXP_W];
    frac      = val_i[FRAC_W-1:0];
    exp_ones  = &expo;
    exp_zero  = ~|expo;
    frac_zero = (~|frac) | (exp_zero & daz_i);
    is_zero   = exp_zero & frac_zero;
    quiet     = frac[FRAC_W-1];

    cat           = '0;
    cat[CAT_QNAN] = exp_ones & ~frac_zero & quiet;
    cat[CAT_SNAN] = exp_ones & ~frac_zero & ~quiet;
    cat[CAT_PZER] = ~sign & is_zero;
    cat[CAT_NZER] = sign & is_zero;
    cat[CAT_PINF] = ~sign & exp_ones & frac_zero;
    cat[CAT_NINF] = sign & exp_ones & frac_zero;
    cat[CAT_DENO] = exp_zero & ~frac_zero;
    cat[CAT_NFIN] = sign & ~exp_ones & ~is_zero;
    hit_o         = |(cat & sel_i);
  end
endmodule

// File: rtl/fpclass_gate.sv
module fpclass_gate
  import fpclass_pkg::*;
#(
  parameter int unsigned LANES = MAX_LANES
) (
  input  logic [LANES-1:0] hit_i,
  input  logic [LANES-1:0] wmask_i,
  input  logic             wmask_en_i,
  input  logic [VL_W-1:0]  vl_i,
  output logic [LANES-1:0] res_o
);
  int unsigned n_act;
  assign n_act = active_lanes(vl_i);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic in_range, keep;
    assign in_range = (j < n_act);
    assign keep     = ~wmask_en_i | wmask_i[j];
    assign res_o[j] = hit_i[j] & in_range & keep;
  end
endmodule

// File: rtl/fpclass_pd.sv
module fpclass_pd
  import fpclass_pkg::*;
#(
  parameter int unsigned LANES = MAX_LANES,
  localparam int unsigned VEC_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [VEC_W-1:0]  src_i,
  input  logic [LANE_W-1:0] scalar_i,
  input  logic [NUM_CAT-1:0] sel_i,
  input  logic [LANES-1:0]  wmask_i,
  input  logic              wmask_en_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic              bcast_i,
  input  logic              daz_i,
  output logic              valid_o,
  output logic [LANES-1:0]  mask_o
);
  logic [LANES-1:0] hit, res;

  for (genvar j = 0; j < LANES; j++) begin : g_cls
    logic [LANE_W-1:0] opnd;
    assign opnd = bcast_i ? scalar_i : src_i[j*LANE_W +: LANE_W];
    fpclass_lane u_lane (
      .val_i (opnd),
      .sel_i (sel_i),
      .daz_i (daz_i),
      .hit_o (hit[j])
    );
  end

  fpclass_gate #(.LANES(LANES)) u_gate (
    .hit_i      (hit),
    .wmask_i    (wmask_i),
    .wmask_en_i (wmask_en_i),
    .vl_i       (vl_i),
    .res_o      (res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      mask_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) mask_o <= res;
    end
  end
endmodule

// File: rtl/fpclass_pd_chk.sv
module fpclass_pd_chk
  import fpclass_pkg::*;
#(
  parameter int unsigned LANES = MAX_LANES
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [NUM_CAT-1:0] sel_i,
  input logic [LANES-1:0]   wmask_i,
  input logic               wmask_en_i,
  input logic [VL_W-1:0]    vl_i,
  input logic               bcast_i,
  input logic               valid_o,
  input logic [LANES-1:0]   mask_o
);
  // R9
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R9
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(mask_o)));
  // R1
  empty_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sel_i == '0) |=> (mask_o == '0));
  // R7
  zero_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && wmask_en_i) |=> ((mask_o & ~$past(wmask_i)) == '0));
  // R6
  upper_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && vl_i == VL_2) |=> (mask_o[LANES-1:2] == '0));
  // R8
  bcast_uniform_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && bcast_i && !wmask_en_i && vl_i[1]) |=> (mask_o == '0 || mask_o == '1));
  // R10
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && mask_o == '0));
endmodule

bind fpclass_pd fpclass_pd_chk #(.LANES(LANES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .sel_i      (sel_i),
  .wmask_i    (wmask_i),
  .wmask_en_i (wmask_en_i),
  .vl_i       (vl_i),
  .bcast_i    (bcast_i),
  .valid_o    (valid_o),
  .mask_o     (mask_o)
);

// File: tb/fpclass_pd_tb_top.sv
module fpclass_pd_tb_top;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [511:0] src_i = '0;
  logic [63:0]  scalar_i = '0;
  logic [7:0]   sel_i = '0;
  logic [7:0]   wmask_i = '0;
  logic         wmask_en_i = 1'b0;
  logic [1:0]   vl_i = 2'd2;
  logic         bcast_i = 1'b0;
  logic         daz_i = 1'b0;
  logic         valid_o;
  logic [7:0]   mask_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fpclass_pd dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .src_i(src_i),
    .scalar_i(scalar_i), .sel_i(sel_i), .wmask_i(wmask_i),
    .wmask_en_i(wmask_en_i), .vl_i(vl_i), .bcast_i(bcast_i),
    .daz_i(daz_i), .valid_o(valid_o), .mask_o(mask_o)
  );

  logic [63:0] cat_vals [16];
  initial begin
    cat_vals[0]  = 64'h0000_0000_0000_0000; // +0
    cat_vals[1]  = 64'h8000_0000_0000_0000; // -0
    cat_vals[2]  = 64'h7FF0_0000_0000_0000; // +inf
    cat_vals[3]  = 64'hFFF0_0000_0000_0000; // -inf
    cat_vals[4]  = 64'h7FF8_0000_0000_0000; // qnan
    cat_vals[5]  = 64'hFFF8_0000_0000_0001; // -qnan
    cat_vals[6]  = 64'h7FF0_0000_0000_0001; // snan
    cat_vals[7]  = 64'hFFF7_FFFF_FFFF_FFFF; // -snan
    cat_vals[8]  = 64'h0000_0000_0000_0001; // +denorm
    cat_vals[9]  = 64'h800F_FFFF_FFFF_FFFF; // -denorm
    cat_vals[10] = 64'h3FF0_0000_0000_0000; // 1.0
    cat_vals[11] = 64'hBFF0_0000_0000_0000; // -1.0
    cat_vals[12] = 64'h7FEF_FFFF_FFFF_FFFF; // max finite
    cat_vals[13] = 64'h8010_0000_0000_0000; // -min normal
    cat_vals[14] = 64'h0008_0000_0000_0000; // denorm, bit51 set
    cat_vals[15] = 64'hFFEF_FFFF_FFFF_FFFF; // -max finite
  end

  // independent model: pick the categories by a decision tree
  function automatic bit ref_lane(input logic [63:0] x, input logic [7:0] s, input bit d);
    bit sg = x[63];
    logic [10:0] e = x[62:52];
    logic [51:0] f = x[51:0];
    if (e == 11'h7FF) begin
      if (f == 0) return sg ? s[4] : s[3];
      return f[51] ? s[0] : s[7];
    end
    if (e == 0 && (f == 0 || d)) return sg ? s[2] : s[1];
    return (e == 0 && s[5]) || (sg && s[6]);
  endfunction

  function automatic logic [7:0] ref_mask(input logic [511:0] v, input logic [63:0] sc,
      input logic [7:0] s, input logic [7:0] wm, input bit wen, input logic [1:0] vl,
      input bit bc, input bit d);
    int n = (vl == 0) ? 2 : (vl == 1) ? 4 : 8;
    logic [7:0] r = '0;
    for (int j = 0; j < 8; j++)
      if (j < n && (!wen || wm[j]))
        r[j] = ref_lane(bc ? sc : v[j*64 +: 64], s, d);
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [511:0] v, input logic [63:0] sc, input logic [7:0] s,
      input logic [7:0] wm, input bit wen, input logic [1:0] vl, input bit bc, input bit d,
      input string tag);
    logic [7:0] exp;
    @(negedge clk);
    src_i = v; scalar_i = sc; sel_i = s; wmask_i = wm; wmask_en_i = wen;
    vl_i = vl; bcast_i = bc; daz_i = d; valid_i = 1'b1;
    exp = ref_mask(v, sc, s, wm, wen, vl, bc, d);
    @(negedge clk);
    valid_i = 1'b0;
    check(valid_o === 1'b1 && mask_o === exp, tag, mask_o, exp);
  endtask

  function automatic logic [511:0] splat(input logic [63:0] x);
    return {8{x}};
  endfunction

  function automatic logic [511:0] rnd_vec();
    logic [511:0] v;
    for (int j = 0; j < 8; j++)
      v[j*64 +: 64] = ($urandom_range(0, 1) == 1) ? cat_vals[$urandom_range(0, 15)]
                                                  : {$urandom, $urandom};
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=00 exp=01");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    // R10
    check(valid_o === 1'b0 && mask_o === 8'h00, "R10 reset", mask_o, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk);

    // directed category points
    run(splat(cat_vals[2]), '0, 8'h08, '0, 0, 2, 0, 0, "R2 +inf");
    run(splat(cat_vals[1]), '0, 8'h04, '0, 0, 2, 0, 0, "R2 -0");
    run(splat(cat_vals[4]), '0, 8'h01, '0, 0, 2, 0, 0, "R3 qnan");
    run(splat(cat_vals[6]), '0, 8'h80, '0, 0, 2, 0, 0, "R3 snan");
    run(splat(cat_vals[8]), '0, 8'h02, '0, 0, 2, 0, 1, "R4 daz to +0");
    run(splat(cat_vals[8]), '0, 8'h20, '0, 0, 2, 0, 1, "R4 daz no denorm");
    run(splat(cat_vals[9]), '0, 8'h40, '0, 0, 2, 0, 0, "R5 neg denorm");
    run(splat(cat_vals[1]), '0, 8'h40, '0, 0, 2, 0, 0, "R5 -0 excluded");

    // R1 R2 R3 R4 R5: every selector over every catalogue value, both daz settings
    for (int v = 0; v < 16; v++)
      for (int s = 0; s < 256; s++)
        for (int d = 0; d < 2; d++)
          run(splat(cat_vals[v]), '0, s[7:0], '0, 0, 2, 0, d[0], "R1 sweep");

    // R6 R7 R8: every write mask against every vl code and broadcast
    for (int m = 0; m < 256; m++)
      for (int vl = 0; vl < 4; vl++)
        for (int b = 0; b < 2; b++)
          run(rnd_vec(), cat_vals[m % 16], 8'hFF, m[7:0], (m % 3) != 0, vl[1:0], b[0],
              0, "R6 R7 R8 sweep");
    run(splat(cat_vals[10]), '0, 8'h40, 8'h00, 0, 2, 0, 0, "R7 mask ignored");
    run(splat(cat_vals[11]), cat_vals[0], 8'h40, '0, 0, 2, 1, 0, "R8 bcast zero");

    // R9: hold when idle
    run(splat(cat_vals[11]), '0, 8'h40, '0, 0, 2, 0, 0, "R9 load");
    held = mask_o;
    @(negedge clk);
    src_i = '0;
    @(negedge clk);
    check(valid_o === 1'b0 && mask_o === held, "R9 hold", mask_o, held);

    // random operands
    for (int i = 0; i < 3000; i++)
      run(rnd_vec(), cat_vals[$urandom_range(0, 15)], 8'($urandom), 8'($urandom),
          1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), "R1 random");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule